// File: doc/BRIEF.md
# Single-Wire Debug Host Acknowledge-Timeout and Abort Sequencer

This block sits on the host side of a single-wire debug link, next to the logic that shifts command bits out. Once a command has been fully sent, the shifter pulses `cmd_start` and tells the block whether the command was a read. The block then leaves the line to its pull-up and watches for the falling edge that begins the target's acknowledge pulse. If that edge arrives in time, the block becomes ready again and no abort is issued.

If the edge does not arrive within a programmable number of target clock cycles, the block raises `aborted` and drives a recovery pulse. It first drives the line low, then drives it high for one target cycle as a speedup pulse, and then releases it. The low phase is one of two kinds:

- The long kind has a length sized near the 128-cycle threshold that makes the target resynchronise.
- The short kind has a length of at least four cycles, so the target can still see the edge. It is used only when it was enabled with the command and the command is not a read, because a missed abort after a read leaves host and target out of step.

`ready` stays low until the whole recovery is finished, so a new command cannot begin while a pending one is still unresolved. The target clock is the host clock divided by `TGT_DIV`. All timing in the requirements below assumes the default `TGT_DIV` of 1, where one target cycle equals one host clock.

Top module: `dbg_abort_sequencer`

## Requirements
- R1: After reset, `ready` is 1, `aborted` is 0 and `line_oe` is 0.
- R2: A `cmd_start` pulse seen while `ready` is 1 is accepted. `ready` reads 0 from the next cycle, and the line stays released (`line_oe` 0) while the acknowledge is awaited.
- R3: A falling edge on `line_in` while waiting ends the wait. `ready` returns to 1 within a few cycles, `aborted` stays 0, and the line is never driven.
- R4: Take the edge that samples an accepted `cmd_start` as edge k, and let `ack_timeout` be T. If no acknowledge edge is seen, `line_oe` becomes 1 with `line_out` 0 after edge k+T+1, and `aborted` becomes 1 in that same cycle. T = 0 is allowed.
- R5: A long abort drives `line_out` 0 with `line_oe` 1 for exactly `LONG_LOW_CYC` cycles (default 128, never below 128). It then drives `line_out` 1 for exactly one cycle. On the following cycle `line_oe` is 0 and `ready` is 1.
- R6: A short abort drives the line low for exactly `SHORT_LOW_CYC` cycles (default 4, never below 4), followed by the same single-cycle speedup. It is used only when `short_abort_en` was 1 and `cmd_is_read` was 0, both sampled together with the accepted `cmd_start`. Otherwise the abort is long.
- R7: A command flagged as a read always receives the long abort, even when `short_abort_en` is 1.
- R8: `cmd_start` is ignored while `ready` is 0. While waiting, it does not restart the timeout. While aborting, it does not change the length of the low phase, and `aborted` stays 1.
- R9: `aborted` stays 1 after the recovery completes. It clears to 0 on the cycle after the next accepted `cmd_start`.
- R10: The line is driven only during the abort low phase and the speedup. At all other times `line_oe` is 0 and `line_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Pulse: command fully sent, begin awaiting the acknowledge |
| cmd_is_read | input | 1 | The command being started is a read (sampled with `cmd_start`) |
| short_abort_en | input | 1 | Permit a short abort for this command (sampled with `cmd_start`) |
| ack_timeout | input | TMO_W | Acknowledge wait limit, in target clock cycles |
| line_in | input | 1 | Sensed level of the debug line |
| line_out | output | 1 | Level driven onto the line when `line_oe` is 1 |
| line_oe | output | 1 | Drive enable for the line; 0 leaves it to the pull-up |
| ready | output | 1 | Idle; a new command may be started |
| aborted | output | 1 | The last command timed out and was aborted |

## Verification
The assertions assume three things about the inputs. First, `line_in` follows the block's own drive whenever `line_oe` is 1. Second, `ack_timeout` is held steady while a command is pending. Third, the read and short-enable flags are only meaningful in the cycle of an accepted start. The stimulus meets these by building `line_in` in the bench: it is the driven value while the block drives, and otherwise it is low only while the modelled target pulls it down. The timeout and the flags are changed only while `ready` is 1. Stray start pulses are injected deliberately in both the waiting and the aborting states, so that R8 is exercised against these rules rather than outside them.

// File: rtl/dbg_abort_pkg.sv
package dbg_abort_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE    = 2'd0,
      SEQ_WAIT    = 2'd1,
      SEQ_LOW     = 2'd2,
      SEQ_SPEEDUP = 2'd3
   } seq_state_t;

   // Protocol floors imposed by the target side.
   localparam int unsigned SYNC_FLOOR_CYC  = 128;
   localparam int unsigned SHORT_FLOOR_CYC = 4;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dbg_tick_gen.sv
module dbg_tick_gen #(
   parameter int unsigned DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   generate
      if (DIV == 1) begin : g_direct
         logic tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= 1'b1;
         end
         assign tick = tick_q;
      end else begin : g_divided
         localparam int unsigned PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            pcnt <= '0;
            else if (pcnt == LAST) pcnt <= '0;
            else                   pcnt <= pcnt + 1'b1;
         end
         assign tick = (pcnt == LAST);
      end
   endgenerate

endmodule

// File: rtl/dbg_line_sense.sv
module dbg_line_sense #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic fall
);

   logic synced;
   logic prev_q;

   generate
      if (STAGES == 1) begin : g_single
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b1;
            else        s_q <= line_in;
         end
         assign synced = s_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], line_in};
         end
         assign synced = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= synced;
   end

   assign fall = prev_q & ~synced;

endmodule

// File: rtl/dbg_abort_fsm.sv
module dbg_abort_fsm
   import dbg_abort_pkg::*;
#(
   parameter int unsigned TMO_W         = 16,
   parameter int unsigned CNT_W         = 16,
   parameter int unsigned LONG_LOW_CYC  = 128,
   parameter int unsigned SHORT_LOW_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ack_fall,
   input  logic             cmd_start,
   input  logic             cmd_is_read,
   input  logic             short_abort_en,
   input  logic [TMO_W-1:0] ack_timeout,
   output seq_state_t       state,
   output logic             aborted
);

   localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LOW_CYC - 1);
   localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_LOW_CYC - 1);

   seq_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             short_q;
   logic             aborted_q;
   logic [CNT_W-1:0] low_last;
   logic [CNT_W-1:0] tmo_limit;

   assign low_last  = short_q ? SHORT_LAST : LONG_LAST;
   assign tmo_limit = CNT_W'(ack_timeout);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         cnt_q     <= '0;
         short_q   <= 1'b0;
         aborted_q <= 1'b0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (cmd_start) begin
                  state_q   <= SEQ_WAIT;
                  cnt_q     <= '0;
                  short_q   <= short_abort_en & ~cmd_is_read;
                  aborted_q <= 1'b0;
               end
            end
            SEQ_WAIT: begin
               if (ack_fall) begin
                  state_q <= SEQ_IDLE;
               end else if (tick) begin
                  if (cnt_q == tmo_limit) begin
                     state_q   <= SEQ_LOW;
                     cnt_q     <= '0;
                     aborted_q <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            SEQ_LOW: begin
               if (tick) begin
                  if (cnt_q == low_last) begin
                     state_q <= SEQ_SPEEDUP;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            SEQ_SPEEDUP: begin
               if (tick) state_q <= SEQ_IDLE;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign state   = state_q;
   assign aborted = aborted_q;

endmodule

// File: rtl/dbg_abort_sequencer.sv
module dbg_abort_sequencer
   import dbg_abort_pkg::*;
#(
   parameter int unsigned TMO_W         = 16,
   parameter int unsigned LONG_LOW_CYC  = 128,
   parameter int unsigned SHORT_LOW_CYC = 4,
   parameter int unsigned TGT_DIV       = 1,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_start,
   input  logic             cmd_is_read,
   input  logic             short_abort_en,
   input  logic [TMO_W-1:0] ack_timeout,
   input  logic             line_in,
   output logic             line_out,
   output logic             line_oe,
   output logic             ready,
   output logic             aborted
);

   localparam int unsigned LOW_W = $clog2(LONG_LOW_CYC);
   localparam int unsigned CNT_W = max_u(TMO_W, LOW_W);

   generate
      if (LONG_LOW_CYC < SYNC_FLOOR_CYC) begin : g_bad_long
         $error("LONG_LOW_CYC must be at least 128");
      end
      if (SHORT_LOW_CYC < SHORT_FLOOR_CYC) begin : g_bad_short
         $error("SHORT_LOW_CYC must be at least 4");
      end
      if (SHORT_LOW_CYC >= LONG_LOW_CYC) begin : g_bad_order
         $error("SHORT_LOW_CYC must be below LONG_LOW_CYC");
      end
      if (TGT_DIV < 1) begin : g_bad_div
         $error("TGT_DIV must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (TMO_W < 1) begin : g_bad_tmo
         $error("TMO_W must be at least 1");
      end
   endgenerate

   logic       tick;
   logic       ack_fall;
   seq_state_t state;

   dbg_tick_gen #(
      .DIV (TGT_DIV)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   dbg_line_sense #(
      .STAGES (SYNC_STAGES)
   ) u_sense (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (line_in),
      .fall    (ack_fall)
   );

   dbg_abort_fsm #(
      .TMO_W         (TMO_W),
      .CNT_W         (CNT_W),
      .LONG_LOW_CYC  (LONG_LOW_CYC),
      .SHORT_LOW_CYC (SHORT_LOW_CYC)
   ) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .tick           (tick),
      .ack_fall       (ack_fall),
      .cmd_start      (cmd_start),
      .cmd_is_read    (cmd_is_read),
      .short_abort_en (short_abort_en),
      .ack_timeout    (ack_timeout),
      .state          (state),
      .aborted        (aborted)
   );

   assign line_oe  = (state == SEQ_LOW) || (state == SEQ_SPEEDUP);
   assign line_out = (state == SEQ_SPEEDUP);
   assign ready    = (state == SEQ_IDLE);

endmodule

// File: rtl/dbg_abort_sequencer_chk.sv
module dbg_abort_sequencer_chk #(
   parameter int unsigned LONG_LOW_CYC  = 128,
   parameter int unsigned SHORT_LOW_CYC = 4
) (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic cmd_start,
   input logic cmd_is_read,
   input logic line_out,
   input logic line_oe,
   input logic ready,
   input logic aborted
);

   int unsigned low_run;
   logic        rd_q;
   logic        hi_drv;

   assign hi_drv = line_oe && line_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run <= 0;
         rd_q    <= 1'b0;
      end else begin
         if (line_oe && !line_out) low_run <= low_run + 1;
         else                      low_run <= 0;
         if (cmd_start && ready)   rd_q <= cmd_is_read;
      end
   end

   AST_IDLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> !line_oe) else $error("idle drives line"); // R10

   AST_OUT_ONLY_WHEN_OE: assert property (@(posedge clk) disable iff (!rst_n)
      line_out |-> line_oe) else $error("level without enable"); // R10

   AST_SPEEDUP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_drv && tick) |=> !hi_drv) else $error("speedup too long"); // R5

   AST_SPEEDUP_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_drv) |-> $past(line_oe && !line_out)) else $error("speedup without low"); // R5

   AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(aborted) |-> (line_oe && !line_out && !ready)) else $error("aborted without low"); // R4

   AST_DRIVE_MEANS_ABORTED: assert property (@(posedge clk) disable iff (!rst_n)
      line_oe |-> aborted) else $error("drive without abort"); // R9

   AST_SHORT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_drv) |-> (low_run >= SHORT_LOW_CYC)) else $error("low too short"); // R6

   AST_READ_LONG: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hi_drv) && rd_q) |-> (low_run >= LONG_LOW_CYC)) else $error("read got short abort"); // R7

endmodule

bind dbg_abort_sequencer dbg_abort_sequencer_chk #(
   .LONG_LOW_CYC  (LONG_LOW_CYC),
   .SHORT_LOW_CYC (SHORT_LOW_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (tick),
   .cmd_start   (cmd_start),
   .cmd_is_read (cmd_is_read),
   .line_out    (line_out),
   .line_oe     (line_oe),
   .ready       (ready),
   .aborted     (aborted)
);

// File: tb/dbg_abort_sequencer_test.sv
module dbg_abort_sequencer_test;

   localparam int CLK_PERIOD = 10;
   localparam int TMO_W      = 16;
   localparam int LONG_LOW   = 128;
   localparam int SHORT_LOW  = 4;
   localparam int WATCHDOG   = 50000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_start = 1'b0;
   logic             cmd_is_read = 1'b0;
   logic             short_abort_en = 1'b0;
   logic [TMO_W-1:0] ack_timeout = '0;
   logic             tgt_low = 1'b0;
   logic             line_in;
   logic             line_out;
   logic             line_oe;
   logic             ready;
   logic             aborted;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   assign line_in = line_oe ? line_out : ~tgt_low;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dbg_abort_sequencer #(
      .TMO_W         (TMO_W),
      .LONG_LOW_CYC  (LONG_LOW),
      .SHORT_LOW_CYC (SHORT_LOW)
   ) uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .cmd_start      (cmd_start),
      .cmd_is_read    (cmd_is_read),
      .short_abort_en (short_abort_en),
      .ack_timeout    (ack_timeout),
      .line_in        (line_in),
      .line_out       (line_out),
      .line_oe        (line_oe),
      .ready          (ready),
      .aborted        (aborted)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Accept a command: strobe sampled at one posedge, back at negedge after it.
   task automatic start_cmd(input bit rd, input bit short_en, input int tmo);
      @(negedge clk);
      cmd_is_read    = rd;
      short_abort_en = short_en;
      ack_timeout    = TMO_W'(tmo);
      cmd_start      = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
   endtask

   // Measure a timeout-driven abort; optionally pulse cmd_start inside it.
   task automatic run_timeout(input string req, input bit rd, input bit short_en,
                              input int tmo, input int exp_low, input bit inject);
      int n;
      start_cmd(rd, short_en, tmo);
      check("R2", "ready low while waiting", int'(ready), 0);
      n = 0;
      while (!line_oe && n < 100000) begin
         if (inject && n == 1) cmd_start = 1'b1;
         @(negedge clk);
         cmd_start = 1'b0;
         n++;
      end
      check("R4", "cycles to abort", n, tmo + 1);
      check("R4", "aborted at abort start", int'(aborted), 1);
      n = 0;
      while (line_oe && !line_out && n < 1000) begin
         if (inject && n == 3) cmd_start = 1'b1;
         @(negedge clk);
         cmd_start = 1'b0;
         n++;
      end
      check(req, "low phase length", n, exp_low);
      check("R5", "speedup drives high", int'(line_oe && line_out), 1);
      @(negedge clk);
      check("R5", "released after one speedup cycle", int'(line_oe), 0);
      check("R5", "ready after recovery", int'(ready), 1);
      check("R9", "aborted held after recovery", int'(aborted), 1);
   endtask

   task automatic t_reset;
      check("R1", "ready after reset", int'(ready), 1);
      check("R1", "aborted after reset", int'(aborted), 0);
      check("R1", "line_oe after reset", int'(line_oe), 0);
   endtask

   task automatic t_ack_ok(input bit rd);
      int drove;
      drove = 0;
      start_cmd(rd, 1'b1, 60);
      check("R2", "ready drops on accept", int'(ready), 0);
      check("R9", "aborted cleared by new command", int'(aborted), 0);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (line_oe) drove++;
      end
      tgt_low = 1'b1;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (line_oe) drove++;
      end
      tgt_low = 1'b0;
      for (int i = 0; i < 70; i++) begin
         @(negedge clk);
         if (line_oe || line_out) drove++;
      end
      check("R3", "ready after acknowledge", int'(ready), 1);
      check("R3", "no abort on acknowledge", int'(aborted), 0);
      check("R10", "line never driven around acknowledge", drove, 0);
   endtask

   task automatic t_long_nonread;
      run_timeout("R5", 1'b0, 1'b0, 20, LONG_LOW, 1'b0);
   endtask

   task automatic t_short_nonread;
      run_timeout("R6", 1'b0, 1'b1, 7, SHORT_LOW, 1'b0);
   endtask

   task automatic t_read_forces_long;
      run_timeout("R7", 1'b1, 1'b1, 3, LONG_LOW, 1'b0);
   endtask

   task automatic t_zero_timeout;
      run_timeout("R4", 1'b0, 1'b1, 0, SHORT_LOW, 1'b0);
   endtask

   task automatic t_busy_strobes;
      run_timeout("R8", 1'b0, 1'b0, 12, LONG_LOW, 1'b1);
   endtask

   task automatic t_released_when_idle;
      int drove;
      drove = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (line_oe || line_out) drove++;
      end
      check("R10", "idle line released", drove, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_released_when_idle();
      t_ack_ok(1'b0);
      t_long_nonread();
      t_released_when_idle();
      t_ack_ok(1'b1);
      t_short_nonread();
      t_read_forces_long();
      t_zero_timeout();
      t_busy_strobes();
      t_ack_ok(1'b0);
      done = 1'b1;
   end

   initial begin
      while (!done && cycles < WATCHDOG) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule